// File: doc/BRIEF.md
# Self-Routing Baseline Switch Network

This block is a multistage interconnect that joins N source ports to N sink ports, with N a power of two. It is built from log2(N) columns of 2x2 switching cells. Each cell reads a single bit of the packet's destination address and uses it to steer the packet to its upper or lower output. There is no central route controller: the path is fixed entirely by the destination the packet carries.

On every cycle each source port offers a valid flag, a destination index and a payload. Packets that reach the end of the fabric appear one clock later on the sink port whose index equals their destination. Two packets can need the same internal link in the same cycle, even when their destinations differ. When that happens the packet that arrived on the cell's upper input keeps the link. The other packet is discarded, and its source's blocked flag is raised for that one cycle. The fabric has no buffering and never retries.

Top module: `baseline_net`

## Requirements
- R1: While `rstN` is low, `outValid` and `outBlocked` are all zero, whatever the inputs are.
- R2: A packet offered alone on any source, with `inValid[i]` high, `inDest[i*S +: S]` = d and payload `inData[i*W +: W]`, appears after the next rising clock edge with `outValid[d]` high and `outData[d*W +: W]` equal to the payload. No other sink is valid, and no blocked flag is set.
- R3: Stage k (k = 0 first) reads destination bit S-1-k, where S = log2(N). Cell c of each stage owns links 2c (upper) and 2c+1 (lower). Bit 0 selects cell output 2c and bit 1 selects 2c+1. Cell output p of stage k feeds link `(p/M)*M + (p%2)*(M/2) + (p%M)/2` of stage k+1, where M = N>>k. After the last stage, link p is sink p.
- R4: Two valid packets that enter the same cell and read the same bit value collide, even when their full destinations differ.
- R5: In a collision, the packet on the cell's upper link wins at every stage. The lower packet is dropped, and only the blocked flag of the source that packet came from is set.
- R6: A source with `inValid` low takes no link and causes no collision, whatever its destination and payload. Its blocked flag stays low.
- R7: Every valid source is either delivered to the sink equal to its destination or flagged blocked, never both. Sinks that no packet reaches have `outValid` low and `outData` zero. The count of valid sinks plus blocked flags equals the count of valid sources of the previous cycle.
- R8: `outBlocked` describes only the packets offered in the previous cycle. A flag falls on the cycle after a cycle without a collision for that source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | N | Per-source packet present |
| inDest | input | N*S | Per-source destination, source i at bits i*S +: S |
| inData | input | N*W | Per-source payload, source i at bits i*W +: W |
| outValid | output | N | Per-sink packet delivered, registered |
| outData | output | N*W | Per-sink payload, sink j at bits j*W +: W, zero when not valid |
| outBlocked | output | N | Per-source packet lost to a collision, registered |

## Verification
The assertions assume that the inputs are stable at each rising edge. They also assume that the sources apply no back-pressure and do not expect a packet to be held or replayed: each cycle is judged alone against the inputs of the cycle before it. The bench drives every input on the falling edge and offers a fresh, independent set of packets each cycle. Sources that are idle still carry deliberately colliding destinations and payloads, so the idle-source assumption is put under stress rather than merely met. The stimulus includes lone packets to every sink, a conflict-free permutation, collisions placed at the first and at a deeper stage, a collision followed by an idle cycle, and many cycles of random traffic with duplicate destinations.

// File: rtl/baseline_pkg.sv
package baseline_pkg;

  // Steering strobes for one 2x2 cell
  typedef struct packed {
    logic swap;   // upper input leaves on the lower output
    logic vld0;   // upper output carries a packet
    logic vld1;   // lower output carries a packet
  } cellCtl_t;

  // Link reached by output p of stage k in a fabric of the given size
  function automatic int nextLine(int stage, int pos, int ports);
    int span;
    int q;
    span = ports >> stage;
    q    = pos % span;
    return (pos - q) + (q % 2) * (span / 2) + q / 2;
  endfunction

endpackage

// File: rtl/baseline_ctrl.sv
module baseline_ctrl
  import baseline_pkg::*;
#(
  parameter int N = 8,
  localparam int S = $clog2(N),
  localparam int C = N / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N-1:0]         inValid,
  input  logic [N*S-1:0]       inDest,
  output cellCtl_t [S*C-1:0]   ctl,
  output logic [N-1:0]         outBlocked
);

  logic [N-1:0] curV, nxtV, blkNext;
  logic [S-1:0] curD [N];
  logic [S-1:0] nxtD [N];
  logic [S-1:0] curS [N];
  logic [S-1:0] nxtS [N];
  logic         uV, lV, uB, lB, clash, sw, v0, v1;
  int           n0, n1;

  // Header walk: same fabric as the payload, carrying valid/destination/source
  always_comb begin
    blkNext = '0;
    ctl     = '0;
    nxtV    = '0;
    uV = 1'b0; lV = 1'b0; uB = 1'b0; lB = 1'b0;
    clash = 1'b0; sw = 1'b0; v0 = 1'b0; v1 = 1'b0;
    n0 = 0; n1 = 0;
    for (int i = 0; i < N; i++) begin
      curV[i] = inValid[i];
      curD[i] = inDest[i*S +: S];
      curS[i] = S'(i);
      nxtD[i] = '0;
      nxtS[i] = '0;
    end
    for (int k = 0; k < S; k++) begin
      nxtV = '0;
      for (int c = 0; c < C; c++) begin
        uV    = curV[2*c];
        lV    = curV[2*c+1];
        uB    = curD[2*c][S-1-k];
        lB    = curD[2*c+1][S-1-k];
        clash = uV && lV && (uB == lB);
        if (clash) blkNext[curS[2*c+1]] = 1'b1;
        sw = uV ? uB : (lV && !lB);
        v0 = (uV && !uB) || (lV && !lB);
        v1 = (uV && uB) || (lV && lB);
        ctl[k*C+c].swap = sw;
        ctl[k*C+c].vld0 = v0;
        ctl[k*C+c].vld1 = v1;
        n0 = nextLine(k, 2*c, N);
        n1 = nextLine(k, 2*c+1, N);
        nxtV[n0] = v0;
        nxtV[n1] = v1;
        nxtD[n0] = sw ? curD[2*c+1] : curD[2*c];
        nxtD[n1] = sw ? curD[2*c]   : curD[2*c+1];
        nxtS[n0] = sw ? curS[2*c+1] : curS[2*c];
        nxtS[n1] = sw ? curS[2*c]   : curS[2*c+1];
      end
      curV = nxtV;
      for (int i = 0; i < N; i++) begin
        curD[i] = nxtD[i];
        curS[i] = nxtS[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBlocked <= '0;
    else       outBlocked <= blkNext;
  end

  // Two valid sources sharing a destination must cost someone a flag
  logic dupDest;
  always_comb begin
    dupDest = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        if (inValid[i] && inValid[j] && inDest[i*S +: S] == inDest[j*S +: S])
          dupDest = 1'b1;
  end

  a_r7_dup_dest_blocks: assert property (@(posedge clk) disable iff (!rstN)
    dupDest |=> (outBlocked != '0));

  a_r8_blocked_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ((outBlocked & ~$past(inValid)) == '0));

endmodule

// File: rtl/baseline_datapath.sv
module baseline_datapath
  import baseline_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int S = $clog2(N),
  localparam int C = N / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cellCtl_t [S*C-1:0]   ctl,
  input  logic [N*W-1:0]       inData,
  output logic [N-1:0]         outValid,
  output logic [N*W-1:0]       outData
);

  logic [W-1:0] curP [N];
  logic [W-1:0] nxtP [N];
  logic [N-1:0] lastV, firstV;
  int           n0, n1;

  always_comb begin
    lastV  = '0;
    firstV = '0;
    n0 = 0; n1 = 0;
    for (int i = 0; i < N; i++) begin
      curP[i] = inData[i*W +: W];
      nxtP[i] = '0;
    end
    for (int k = 0; k < S; k++) begin
      for (int c = 0; c < C; c++) begin
        n0 = nextLine(k, 2*c, N);
        n1 = nextLine(k, 2*c+1, N);
        nxtP[n0] = ctl[k*C+c].swap ? curP[2*c+1] : curP[2*c];
        nxtP[n1] = ctl[k*C+c].swap ? curP[2*c]   : curP[2*c+1];
        if (k == 0) begin
          firstV[2*c]   = ctl[c].vld0;
          firstV[2*c+1] = ctl[c].vld1;
        end
        if (k == S - 1) begin
          lastV[n0] = ctl[k*C+c].vld0;
          lastV[n1] = ctl[k*C+c].vld1;
        end
      end
      for (int i = 0; i < N; i++) curP[i] = nxtP[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      outData  <= '0;
    end else begin
      outValid <= lastV;
      for (int j = 0; j < N; j++)
        outData[j*W +: W] <= lastV[j] ? curP[j] : '0;
    end
  end

  // Later stages can only lose packets, never create them
  a_r7_fabric_no_gain: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lastV) <= $countones(firstV));

endmodule

// File: rtl/baseline_net.sv
module baseline_net
  import baseline_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 8,
  localparam int S = $clog2(N),
  localparam int C = N / 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   inValid,
  input  logic [N*S-1:0] inDest,
  input  logic [N*W-1:0] inData,
  output logic [N-1:0]   outValid,
  output logic [N*W-1:0] outData,
  output logic [N-1:0]   outBlocked
);

  cellCtl_t [S*C-1:0] ctl;

  baseline_ctrl #(.N(N)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest),
    .ctl(ctl), .outBlocked(outBlocked)
  );

  baseline_datapath #(.N(N), .W(W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  a_r7_conserve: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(outValid) + $countones(outBlocked) == $countones($past(inValid))));

  a_r7_never_both_lost: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(outBlocked) <= $countones($past(inValid))));

  a_r2_lone_delivered: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && $countones(inValid) == 1) |=> ($countones(outValid) == 1 && outBlocked == '0));

endmodule

// File: tb/tb_baseline_net.sv
`timescale 1ns/100ps
module tb_baseline_net;
  localparam int N = 8;
  localparam int W = 8;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]   inValid = '0;
  logic [N*S-1:0] inDest = '0;
  logic [N*W-1:0] inData = '0;
  logic [N-1:0]   outValid;
  logic [N*W-1:0] outData;
  logic [N-1:0]   outBlocked;

  baseline_net #(.N(N), .W(W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDest(inDest), .inData(inData),
    .outValid(outValid), .outData(outData), .outBlocked(outBlocked)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0]   dV;
  logic [S-1:0]   dD [N];
  logic [W-1:0]   dP [N];

  logic [N-1:0]   evQ [$];
  logic [N-1:0]   ebQ [$];
  logic [N*W-1:0] edQ [$];
  string          tagQ [$];

  task automatic check(string tag, string what, logic [N*W-1:0] act, logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic clearDrive();
    dV = '0;
    for (int i = 0; i < N; i++) begin
      dD[i] = '0;
      dP[i] = '0;
    end
  endtask

  // Drive one cycle and queue what the requirements predict for it
  task automatic apply(string tag);
    int line [N];
    bit live [N];
    bit drop [N];
    int pos;
    int span;
    logic [N-1:0]   ev = '0;
    logic [N-1:0]   eb = '0;
    logic [N*W-1:0] ed = '0;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      inValid[i]       = dV[i];
      inDest[i*S +: S] = dD[i];
      inData[i*W +: W] = dP[i];
      line[i] = i;
      live[i] = dV[i];
    end
    for (int k = 0; k < S; k++) begin
      for (int i = 0; i < N; i++) drop[i] = 1'b0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && live[i] && live[j] && line[i] / 2 == line[j] / 2 &&
              line[j] % 2 == 0 && dD[i][S-1-k] == dD[j][S-1-k])
            drop[i] = 1'b1;
      for (int i = 0; i < N; i++)
        if (drop[i]) begin
          live[i] = 1'b0;
          eb[i]   = 1'b1;
        end
      span = N >> k;
      for (int i = 0; i < N; i++)
        if (live[i]) begin
          pos = (line[i] / 2) * 2 + int'(dD[i][S-1-k]);
          line[i] = (pos / span) * span + (pos % 2) * (span / 2) + (pos % span) / 2;
        end
    end
    for (int i = 0; i < N; i++)
      if (live[i]) begin
        ev[line[i]] = 1'b1;
        ed[line[i]*W +: W] = dP[i];
      end
    evQ.push_back(ev);
    ebQ.push_back(eb);
    edQ.push_back(ed);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare each registered result one step after its capture edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (evQ.size() > 0) begin
        logic [N-1:0]   ev;
        logic [N-1:0]   eb;
        logic [N*W-1:0] ed;
        logic [N*W-1:0] ad;
        string          tag;
        ev = evQ.pop_front();
        eb = ebQ.pop_front();
        ed = edQ.pop_front();
        tag = tagQ.pop_front();
        ad = '0;
        for (int j = 0; j < N; j++)
          ad[j*W +: W] = outData[j*W +: W];
        check(tag, "outValid", {{(N*W-N){1'b0}}, outValid}, {{(N*W-N){1'b0}}, ev});
        check(tag, "outBlocked", {{(N*W-N){1'b0}}, outBlocked}, {{(N*W-N){1'b0}}, eb});
        check(tag, "outData", ad, ed);
      end
    end
  end

  function automatic logic [S-1:0] bitRev(int v);
    logic [S-1:0] r;
    for (int b = 0; b < S; b++) r[b] = v[S-1-b];
    return r;
  endfunction

  initial begin
    // R1: reset holds outputs low even with traffic offered
    @(negedge clk);
    inValid = '1;
    for (int i = 0; i < N; i++) begin
      inDest[i*S +: S] = S'(i);
      inData[i*W +: W] = W'(8'hA0 + i);
    end
    @(posedge clk);
    #1;
    check("R1", "outValid in reset", {{(N*W-N){1'b0}}, outValid}, '0);
    check("R1", "outBlocked in reset", {{(N*W-N){1'b0}}, outBlocked}, '0);
    check("R1", "outData in reset", outData, '0);
    @(negedge clk);
    inValid = '0;
    rstN = 1'b1;

    // R2: every source to every sink, alone
    for (int s = 0; s < N; s++)
      for (int d = 0; d < N; d++) begin
        clearDrive();
        dV[s] = 1'b1;
        dD[s] = S'(d);
        dP[s] = W'(s * 16 + d);
        apply("R2");
      end

    // R3: bit-reversal permutation, all sources live
    clearDrive();
    for (int i = 0; i < N; i++) begin
      dV[i] = 1'b1;
      dD[i] = bitRev(i);
      dP[i] = W'(8'h30 + i);
    end
    apply("R3");

    // R4: shared first-stage cell, different destinations, same MSB
    clearDrive();
    dV[0] = 1'b1; dD[0] = 3'd0; dP[0] = 8'h11;
    dV[1] = 1'b1; dD[1] = 3'd1; dP[1] = 8'h22;
    apply("R4");

    // R5: collision at the second stage, upper link keeps it
    clearDrive();
    dV[0] = 1'b1; dD[0] = 3'd0; dP[0] = 8'h44;
    dV[2] = 1'b1; dD[2] = 3'd1; dP[2] = 8'h55;
    apply("R5");
    clearDrive();
    dV[0] = 1'b1; dD[0] = 3'd1; dP[0] = 8'h66;
    dV[2] = 1'b1; dD[2] = 3'd0; dP[2] = 8'h77;
    apply("R5");

    // R6: idle sources carry clashing destinations and payloads
    clearDrive();
    for (int i = 0; i < N; i++) begin
      dD[i] = 3'd3;
      dP[i] = 8'hEE;
    end
    dV[0] = 1'b1; dP[0] = 8'h5A;
    apply("R6");
    clearDrive();
    for (int i = 0; i < N; i++) begin
      dD[i] = 3'd6;
      dP[i] = 8'hDD;
    end
    dV[5] = 1'b1; dP[5] = 8'hC3;
    apply("R6");

    // R8: a flag lasts one cycle only
    clearDrive();
    dV[2] = 1'b1; dD[2] = 3'd4; dP[2] = 8'h12;
    dV[3] = 1'b1; dD[3] = 3'd5; dP[3] = 8'h34;
    apply("R8");
    clearDrive();
    apply("R8");
    clearDrive();
    dV[3] = 1'b1; dD[3] = 3'd5; dP[3] = 8'h56;
    apply("R8");

    // R7: all sources to one sink, then random traffic
    clearDrive();
    for (int i = 0; i < N; i++) begin
      dV[i] = 1'b1;
      dD[i] = 3'd5;
      dP[i] = W'(8'h80 + i);
    end
    apply("R7");
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < N; i++) begin
        dV[i] = 1'($urandom);
        dD[i] = S'($urandom);
        dP[i] = W'($urandom);
      end
      apply("R7");
    end

    clearDrive();
    apply("R7");
    apply("R7");
    @(negedge clk);
    inValid = '0;
    while (evQ.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule